// File: doc/BRIEF.md
# Exception Status and Cause Register File

This block holds the four exception-control registers that a simple 32-bit RISC core needs to take and return from traps: a processor status word, a cause word, the exception program counter and the bad virtual address. The core reads and writes them by register number through a single move-to / move-from port. The read path is combinational, and writes take effect at the next clock edge.

When the core takes an exception, it pulses `exc_take` together with a 4-bit reason code, the PC of the faulting instruction and the faulting data address. The block then pushes the three-level mode/enable stack in the status word. Kernel mode with interrupts disabled becomes the current state, and the reason and PC are recorded. A pulse on `rfe` pops the stack on the way out of a handler. Five external interrupt lines are sampled into the pending field of the cause word. The block raises `irq_out` when the current enable bit allows interrupts and a pending level is unmasked.

Top module: `trap_ctl_regs`

## Requirements
- R1: After a synchronous reset, all four registers read 0 and `irq_out` is 0. This state is kernel mode with interrupts disabled.
- R2: The register numbers are 8 for bad address, 12 for status, 13 for cause and 14 for EPC. `rd_data` shows the register selected by `reg_sel` in the same cycle, and every other number reads 0.
- R3: A move-to write to status stores bits 12:8 (interrupt mask) and bits 5:0 (mode/enable stack), and all other status bits read 0. A write to EPC stores the full word. Writes to cause, to bad address and to unmapped numbers change nothing.
- R4: Status bits 5:0 hold three pairs: current at 1:0, previous at 3:2 and old at 5:4. Within each pair, bit 0 is interrupt enable and bit 1 is the user-mode flag (1 means user mode). On exception entry the stack becomes {old bits 3:0, 2'b00}.
- R5: On return-from-exception the stack becomes {bits 5:4, bits 5:2}. Old is copied into previous, previous into current, and old keeps its value.
- R6: On exception entry, cause bits 5:2 take `exc_code` and EPC takes `exc_pc`. The codes are: 0 interrupt, 4 load/fetch address error, 5 store address error, 6 fetch bus error, 7 data bus error, 8 system call, 9 breakpoint, 10 reserved instruction, 12 overflow.
- R7: The bad-address register loads `exc_addr` only on an exception with code 4 or 5. Otherwise it holds its value.
- R8: Cause bits 12:8 show the level of `irq_in` sampled at the previous clock edge.
- R9: `irq_out` is 1 exactly when status bit 0 is 1 and some cause pending bit in 12:8 is 1 while the matching status mask bit is also 1.
- R10: Exception entry takes priority over return-from-exception and over any move-to write in the same cycle. Return-from-exception takes priority over a move-to write. A write that loses priority is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 5 | Register number for read and write |
| wr_en | input | 1 | Move-to write strobe |
| wr_data | input | 32 | Move-to write data |
| rd_data | output | 32 | Move-from read data (combinational) |
| exc_take | input | 1 | Exception entry strobe |
| exc_code | input | 4 | Exception reason code |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_addr | input | 32 | Faulting data address |
| rfe | input | 1 | Return-from-exception strobe |
| irq_in | input | 5 | External interrupt request levels |
| irq_out | output | 1 | Interrupt request to the core |

## Verification
Every register update from a write, an exception entry, a return or an interrupt-line change is visible one clock edge after the stimulus. `rd_data` and `irq_out` are combinational from the registers, so they settle in the same half-cycle as the update. The bench drives each stimulus at a falling edge and lets one rising edge pass. Within the low phase that follows, it sweeps `reg_sel` over the four registers and compares each read and `irq_out` against a bench model advanced at that same edge.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int XLEN      = 32;
    localparam int NIRQ      = 5;
    localparam int SEL_W     = 5;
    localparam int CODE_W    = 4;
    localparam int STACK_W   = 6;

    localparam logic [SEL_W-1:0] SEL_BADADDR = 5'd8;
    localparam logic [SEL_W-1:0] SEL_STATUS  = 5'd12;
    localparam logic [SEL_W-1:0] SEL_CAUSE   = 5'd13;
    localparam logic [SEL_W-1:0] SEL_EPC     = 5'd14;

    localparam logic [CODE_W-1:0] CODE_ADDR_LD = 4'd4;
    localparam logic [CODE_W-1:0] CODE_ADDR_ST = 4'd5;

    typedef struct packed {
        logic [XLEN-14:0]   rsv_hi;
        logic [NIRQ-1:0]    mask;
        logic [1:0]         rsv_mid;
        logic [STACK_W-1:0] stack;
    } status_t;

    typedef struct packed {
        logic [XLEN-14:0]   rsv_hi;
        logic [NIRQ-1:0]    pend;
        logic [1:0]         rsv_mid;
        logic [CODE_W-1:0]  code;
        logic [1:0]         rsv_lo;
    } cause_t;

    function automatic logic [STACK_W-1:0] stack_push(input logic [STACK_W-1:0] s);
        return {s[STACK_W-3:0], 2'b00};
    endfunction

    function automatic logic [STACK_W-1:0] stack_pop(input logic [STACK_W-1:0] s);
        return {s[STACK_W-1:STACK_W-2], s[STACK_W-1:2]};
    endfunction

    function automatic logic is_addr_fault(input logic [CODE_W-1:0] c);
        return (c == CODE_ADDR_LD) || (c == CODE_ADDR_ST);
    endfunction
endpackage

// File: rtl/trap_status.sv
module trap_status
    import trap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic            wr,
    input  logic [XLEN-1:0] wdata,
    output status_t         q
);
    status_t wr_val;

    always_comb begin
        wr_val         = status_t'(wdata);
        wr_val.rsv_hi  = '0;
        wr_val.rsv_mid = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (push) begin
            q.stack <= stack_push(q.stack);
        end else if (pop) begin
            q.stack <= stack_pop(q.stack);
        end else if (wr) begin
            q <= wr_val;
        end
    end
endmodule

// File: rtl/trap_cause.sv
module trap_cause
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_code,
    input  logic [CODE_W-1:0] code,
    input  logic [NIRQ-1:0]   irq_in,
    output cause_t            q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.pend <= irq_in;
            if (load_code)
                q.code <= code;
        end
    end
endmodule

// File: rtl/trap_addr_regs.sv
module trap_addr_regs
    import trap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_take,
    input  logic            cap_bad,
    input  logic [XLEN-1:0] exc_pc,
    input  logic [XLEN-1:0] exc_addr,
    input  logic            epc_wr,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] bad_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q <= '0;
            bad_q <= '0;
        end else begin
            if (exc_take)
                epc_q <= exc_pc;
            else if (epc_wr)
                epc_q <= wdata;
            if (exc_take && cap_bad)
                bad_q <= exc_addr;
        end
    end
endmodule

// File: rtl/trap_ctl_regs.sv
module trap_ctl_regs
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              wr_en,
    input  logic [XLEN-1:0]   wr_data,
    output logic [XLEN-1:0]   rd_data,
    input  logic              exc_take,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic [XLEN-1:0]   exc_addr,
    input  logic              rfe,
    input  logic [NIRQ-1:0]   irq_in,
    output logic              irq_out
);
    status_t         stat_q;
    cause_t          cause_q;
    logic [XLEN-1:0] epc_q;
    logic [XLEN-1:0] bad_q;
    logic            pop_go;
    logic            sw_write;

    assign pop_go   = rfe && !exc_take;
    assign sw_write = wr_en && !exc_take && !rfe;

    trap_status u_status (
        .clk   (clk),
        .rst   (rst),
        .push  (exc_take),
        .pop   (pop_go),
        .wr    (sw_write && (reg_sel == SEL_STATUS)),
        .wdata (wr_data),
        .q     (stat_q)
    );

    trap_cause u_cause (
        .clk       (clk),
        .rst       (rst),
        .load_code (exc_take),
        .code      (exc_code),
        .irq_in    (irq_in),
        .q         (cause_q)
    );

    trap_addr_regs u_addr (
        .clk      (clk),
        .rst      (rst),
        .exc_take (exc_take),
        .cap_bad  (is_addr_fault(exc_code)),
        .exc_pc   (exc_pc),
        .exc_addr (exc_addr),
        .epc_wr   (sw_write && (reg_sel == SEL_EPC)),
        .wdata    (wr_data),
        .epc_q    (epc_q),
        .bad_q    (bad_q)
    );

    always_comb begin
        case (reg_sel)
            SEL_BADADDR: rd_data = bad_q;
            SEL_STATUS:  rd_data = stat_q;
            SEL_CAUSE:   rd_data = cause_q;
            SEL_EPC:     rd_data = epc_q;
            default:     rd_data = '0;
        endcase
    end

    assign irq_out = stat_q.stack[0] && |(cause_q.pend & stat_q.mask);
endmodule

// File: rtl/trap_ctl_regs_chk.sv
module trap_ctl_regs_chk
    import trap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              exc_take,
    input logic [CODE_W-1:0] exc_code,
    input logic [XLEN-1:0]   exc_pc,
    input logic              rfe,
    input logic              wr_en,
    input logic [SEL_W-1:0]  reg_sel,
    input logic [NIRQ-1:0]   irq_in,
    input logic              irq_out,
    input status_t           stat_q,
    input cause_t            cause_q,
    input logic [XLEN-1:0]   epc_q,
    input logic [XLEN-1:0]   bad_q
);
    assert_push_R4: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> stat_q.stack == {$past(stat_q.stack[3:0]), 2'b00});

    assert_pop_R5: assert property (@(posedge clk) disable iff (rst)
        (rfe && !exc_take) |=> stat_q.stack == {$past(stat_q.stack[5:4]), $past(stat_q.stack[5:2])});

    assert_epc_R6: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> (epc_q == $past(exc_pc)) && (cause_q.code == $past(exc_code)));

    assert_bad_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (exc_take && exc_code != 4'd4 && exc_code != 4'd5) |=> $stable(bad_q));

    assert_cause_ro_R3: assert property (@(posedge clk) disable iff (rst)
        (!exc_take && wr_en && reg_sel == 5'd13) |=> $stable(cause_q.code));

    assert_pend_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> cause_q.pend == $past(irq_in));

    assert_irq_R9: assert property (@(posedge clk) disable iff (rst)
        (!stat_q.stack[0]) |-> !irq_out);

    assert_prio_R10: assert property (@(posedge clk) disable iff (rst)
        (exc_take && rfe) |=> stat_q.stack[1:0] == 2'b00);
endmodule

bind trap_ctl_regs trap_ctl_regs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .exc_take (exc_take),
    .exc_code (exc_code),
    .exc_pc   (exc_pc),
    .rfe      (rfe),
    .wr_en    (wr_en),
    .reg_sel  (reg_sel),
    .irq_in   (irq_in),
    .irq_out  (irq_out),
    .stat_q   (stat_q),
    .cause_q  (cause_q),
    .epc_q    (epc_q),
    .bad_q    (bad_q)
);

// File: tb/sim_trap_ctl_regs.sv
`timescale 1ns/100ps
module sim_trap_ctl_regs;
    logic        clk = 0;
    logic        rst;
    logic [4:0]  reg_sel;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        exc_take;
    logic [3:0]  exc_code;
    logic [31:0] exc_pc;
    logic [31:0] exc_addr;
    logic        rfe;
    logic [4:0]  irq_in;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] m_st, m_ca, m_epc, m_bad;

    always #4 clk = ~clk;

    trap_ctl_regs u0 (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .exc_take(exc_take), .exc_code(exc_code), .exc_pc(exc_pc),
        .exc_addr(exc_addr), .rfe(rfe), .irq_in(irq_in), .irq_out(irq_out)
    );

    function automatic bit exp_irq(input logic [31:0] st, input logic [31:0] ca);
        return st[0] && |(ca[12:8] & st[12:8]);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [5:0] s;
        s = m_st[5:0];
        if (exc_take) begin
            m_st[5:0] = {s[3:0], 2'b00};
            m_ca[5:2] = exc_code;
            m_epc     = exc_pc;
            if (exc_code == 4'd4 || exc_code == 4'd5) m_bad = exc_addr;
        end else if (rfe) begin
            m_st[5:0] = {s[5:4], s[5:2]};
        end else if (wr_en) begin
            if (reg_sel == 5'd12) m_st = wr_data & 32'h0000_1F3F;
            if (reg_sel == 5'd14) m_epc = wr_data;
        end
        m_ca[12:8] = irq_in;
    endtask

    task automatic verify(input string tag);
        reg_sel = 5'd12; #0.5; check({tag, " R4 status"}, rd_data, m_st);
        reg_sel = 5'd13; #0.5; check({tag, " R6 cause"},  rd_data, m_ca);
        reg_sel = 5'd14; #0.5; check({tag, " R6 epc"},    rd_data, m_epc);
        reg_sel = 5'd8;  #0.5; check({tag, " R7 badaddr"}, rd_data, m_bad);
        check({tag, " R9 irq_out"}, {31'b0, irq_out}, {31'b0, exp_irq(m_st, m_ca)});
    endtask

    task automatic step(input string tag, input bit w, input logic [4:0] sel, input logic [31:0] d,
                        input bit ex, input logic [3:0] c, input bit r, input logic [4:0] irq);
        @(negedge clk);
        wr_en = w; reg_sel = sel; wr_data = d; exc_take = ex; exc_code = c;
        exc_pc = $urandom; exc_addr = $urandom; rfe = r; irq_in = irq;
        @(posedge clk);
        model_edge();
        #1;
        wr_en = 0; exc_take = 0; rfe = 0;
        verify(tag);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [3:0] codes [9] = '{4'd0, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd12};
        void'($urandom(32'd1357));
        rst = 1; wr_en = 0; reg_sel = 0; wr_data = 0; exc_take = 0; exc_code = 0;
        exc_pc = 0; exc_addr = 0; rfe = 0; irq_in = 5'h1F;
        m_st = 0; m_ca = 0; m_epc = 0; m_bad = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        verify("R1 reset");
        rst = 0;
        irq_in = 0;
        @(posedge clk); model_edge(); #1;

        // R3: status write masks reserved bits, cause write ignored
        step("R3 wr status", 1, 5'd12, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step("R3 wr cause", 1, 5'd13, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step("R3 wr bad", 1, 5'd8, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step("R3 wr epc", 1, 5'd14, 32'h1234_5678, 0, 0, 0, 0);
        // R2: unmapped reads zero
        reg_sel = 5'd9; #0.5; check("R2 unmapped 9", rd_data, 32'h0);
        reg_sel = 5'd31; #0.5; check("R2 unmapped 31", rd_data, 32'h0);
        // R8/R9: pending lines vs mask and enable
        step("R8 pend", 0, 0, 0, 0, 0, 0, 5'b00100);
        step("R9 masked off", 1, 5'd12, 32'h0000_0B01, 0, 0, 0, 5'b00100);
        step("R9 enabled", 0, 0, 0, 0, 0, 0, 5'b01000);
        // R4/R7: address error fills bad address; R6 code
        step("R7 addr load", 0, 0, 0, 1, 4'd4, 0, 0);
        step("R7 syscall", 0, 0, 0, 1, 4'd8, 0, 0);
        step("R5 pop", 0, 0, 0, 0, 0, 1, 0);
        step("R5 pop2", 0, 0, 0, 0, 0, 1, 0);
        // R10: collisions
        step("R10 exc+wr", 1, 5'd12, 32'h0000_003F, 1, 4'd5, 0, 0);
        step("R10 exc+rfe", 0, 0, 0, 1, 4'd9, 1, 0);
        step("R10 rfe+wr", 1, 5'd14, 32'hDEAD_BEEF, 0, 0, 1, 0);

        for (int i = 0; i < 400; i++) begin
            int k;
            logic [4:0] sel;
            k = $urandom_range(0, 9);
            case ($urandom_range(0, 4))
                0: sel = 5'd12; 1: sel = 5'd13; 2: sel = 5'd14; 3: sel = 5'd8;
                default: sel = 5'($urandom);
            endcase
            step("R4 rand", k < 4, sel, $urandom, k == 4 || k == 5 || k == 9,
                 codes[$urandom_range(0, 8)], k == 6 || k == 7 || k == 9, 5'($urandom));
        end

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule